// File: doc/BRIEF.md
# Speculative Load Validity Table

A compiler can hoist a load above stores that might write the same bytes. This block tracks every hoisted load that is still in flight, so a later check can decide whether the early value is still good. It keeps one record per destination register, holding the physical address and the access size. When the load issues, the allocate stream writes a record. Every store the core performs is shown on the snoop pins. A store whose bytes touch a recorded range removes that record.

A check names a register and one of two kinds. A reloading check reports nothing wrong when the record is present, and asks for the load to be reissued when it is absent. A branching check asks for a jump to recovery code when the record is absent. A speculative load that has deferred a fault leaves no record, so its check always fails. A flush input empties the table on a context switch.

Back-pressure rules: the allocate and check streams are valid/ready. A transfer happens in a cycle where both valid and ready are high. Ready is low only in a cycle where `flush_all` is high, and a source must then hold its request. The result is not back-pressured: `rs_valid` pulses for one cycle, one cycle after the check transfer. The snoop pins are plain and are always taken.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table is empty, `rs_valid` is 0, and both ready outputs are 1 while `flush_all` is low.
- R2: An accepted allocate without the defer flag creates the record for `al_reg`. If the register already has a record, that record is replaced. No register ever has more than one record.
- R3: Each accepted check gives exactly one `rs_valid` pulse in the next cycle. For a reloading check (`ck_kind`=0) the code is 0 (valid) when a record exists and 1 (reload) when none exists.
- R4: For a branching check (`ck_kind`=1) the code is 0 when a record exists and 2 (recover) when none exists.
- R5: A reloading check that finds its record removes it, so a second reloading check gets code 1. A branching check leaves the record in place.
- R6: An accepted allocate with `al_defer`=1 writes no record and removes any existing record for that register.
- R7: A store of 2^`st_size` bytes at `st_addr` removes every record whose range [addr, addr+2^size) shares at least one byte with it. Ranges that only touch end to end are kept.
- R8: When a store removes a record in the same cycle that a check reads it, the check sees a miss.
- R9: With all 32 entries in use, an allocate for a register that has no record evicts the entry written least recently.
- R10: A cycle with `flush_all`=1 removes every record and drives both ready outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_all | input | 1 | Empty the table (context switch) |
| al_valid | input | 1 | Allocate request present |
| al_ready | output | 1 | Allocate can be accepted |
| al_reg | input | 7 | Destination register of the hoisted load |
| al_addr | input | 32 | Physical byte address |
| al_size | input | 2 | log2 of access bytes (0..3 = 1..8 bytes) |
| al_defer | input | 1 | Load deferred a fault; allocate nothing |
| st_valid | input | 1 | A store is performed this cycle |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | log2 of store bytes |
| ck_valid | input | 1 | Check request present |
| ck_ready | output | 1 | Check can be accepted |
| ck_reg | input | 7 | Register being checked |
| ck_kind | input | 1 | 0 reloading check, 1 branching check |
| rs_valid | output | 1 | Check answer present |
| rs_code | output | 2 | 0 valid, 1 reload, 2 recover |

## Verification
Table state can only be seen through check answers. A lost record, a stale record or a record in the wrong slot shows up as a wrong code on the first check of that register, one cycle after the check is accepted. A wrong age order shows up only after the table has filled and a later allocate evicts the wrong register. The bench therefore fills the table completely and probes the registers on both sides of each eviction. Range-overlap mistakes show up only at byte boundaries, so stores are placed exactly adjacent to recorded ranges and also one byte inside them.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_RELOAD  = 2'd1,
    RES_RECOVER = 2'd2
  } res_e;

  localparam logic KIND_RELOAD = 1'b0;
  localparam logic KIND_BRANCH = 1'b1;

  // byte count of a log2-encoded access size
  function automatic logic [3:0] size_bytes(input logic [1:0] s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/slt_first.sv
module slt_first #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slt_age.sv
module slt_age #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid_vec,
  output logic [IW-1:0] oldest_idx
);
  // older_q[i][j] set: entry i was written before entry j
  logic [N-1:0] older_q [N];
  logic [N-1:0] cand;
  logic         cand_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) older_q[i] <= '0;
        else                     older_q[i][touch_idx] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cand
    assign cand[g] = valid_vec[g] &
                     (&(older_q[g] | ~valid_vec | (N'(1) << g)));
  end

  slt_first #(.N(N)) u_pick (.req(cand), .found(cand_any), .idx(oldest_idx));

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> ($countones(cand) == 1)); // R9
endmodule

// File: rtl/slt_store.sv
module slt_store #(
  parameter int N      = 32,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [N-1:0]      clr_vec,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [REG_W-1:0]  al_reg,
  input  logic [REG_W-1:0]  ck_reg,
  output logic [N-1:0]      valid_vec,
  output logic [N-1:0]      al_match,
  output logic [N-1:0]      ck_hit
);
  import slt_pkg::*;
  localparam int XW = ADDR_W + 1;

  logic [N-1:0]      vld_q;
  logic [REG_W-1:0]  reg_q  [N];
  logic [ADDR_W-1:0] addr_q [N];
  logic [1:0]        size_q [N];
  logic [N-1:0]      snoop_hit;
  logic [XW-1:0]     st_lo, st_hi;

  assign st_lo = {1'b0, st_addr};
  assign st_hi = st_lo + XW'(size_bytes(st_size));

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [XW-1:0] lo, hi;
    assign lo           = {1'b0, addr_q[g]};
    assign hi           = lo + XW'(size_bytes(size_q[g]));
    assign snoop_hit[g] = st_valid & vld_q[g] & (lo < st_hi) & (st_lo < hi);
    assign al_match[g]  = vld_q[g] & (reg_q[g] == al_reg);
    // a store in the same cycle overrides the lookup
    assign ck_hit[g]    = vld_q[g] & (reg_q[g] == ck_reg) & ~snoop_hit[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        reg_q[g]  <= '0;
        addr_q[g] <= '0;
        size_q[g] <= '0;
      end else if (flush) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        vld_q[g]  <= 1'b1;
        reg_q[g]  <= wr_reg;
        addr_q[g] <= wr_addr;
        size_q[g] <= wr_size;
      end else if (snoop_hit[g] || clr_vec[g]) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  assign valid_vec = vld_q;

  AST_ONE_REC_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(al_match) <= 1); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R10
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              al_valid,
  output logic              al_ready,
  input  logic [REG_W-1:0]  al_reg,
  input  logic [ADDR_W-1:0] al_addr,
  input  logic [1:0]        al_size,
  input  logic              al_defer,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              ck_valid,
  output logic              ck_ready,
  input  logic [REG_W-1:0]  ck_reg,
  input  logic              ck_kind,
  output logic              rs_valid,
  output logic [1:0]        rs_code
);
  import slt_pkg::*;

  logic [ENTRIES-1:0] valid_vec, al_match, ck_hit, clr_vec;
  logic               al_fire, ck_fire, wr_en;
  logic               same_found, free_found, ck_found;
  logic [IW-1:0]      same_idx, free_idx, old_idx, wr_idx, ck_idx;
  res_e               code_d;
  logic               rs_valid_q;
  logic [1:0]         rs_code_q;

  assign al_ready = ~flush_all;
  assign ck_ready = ~flush_all;
  assign al_fire  = al_valid & al_ready;
  assign ck_fire  = ck_valid & ck_ready;

  slt_first #(.N(ENTRIES)) u_same (.req(al_match),   .found(same_found), .idx(same_idx));
  slt_first #(.N(ENTRIES)) u_free (.req(~valid_vec), .found(free_found), .idx(free_idx));
  slt_first #(.N(ENTRIES)) u_ckf  (.req(ck_hit),     .found(ck_found),   .idx(ck_idx));

  slt_age #(.N(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .touch(wr_en), .touch_idx(wr_idx),
    .valid_vec(valid_vec), .oldest_idx(old_idx));

  // existing record first, then a free slot, then the oldest entry
  always_comb begin
    if (same_found)      wr_idx = same_idx;
    else if (free_found) wr_idx = free_idx;
    else                 wr_idx = old_idx;
  end
  assign wr_en = al_fire & ~al_defer;

  always_comb begin
    clr_vec = '0;
    if (al_fire && al_defer) clr_vec = clr_vec | al_match;
    if (ck_fire && ck_kind == KIND_RELOAD) clr_vec = clr_vec | ck_hit;
  end

  slt_store #(.N(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_reg(al_reg), .wr_addr(al_addr),
    .wr_size(al_size), .clr_vec(clr_vec),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .al_reg(al_reg), .ck_reg(ck_reg),
    .valid_vec(valid_vec), .al_match(al_match), .ck_hit(ck_hit));

  always_comb begin
    if (ck_found)                 code_d = RES_OK;
    else if (ck_kind == KIND_BRANCH) code_d = RES_RECOVER;
    else                          code_d = RES_RELOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_code_q  <= 2'd0;
    end else begin
      rs_valid_q <= ck_fire;
      if (ck_fire) rs_code_q <= code_d;
    end
  end

  assign rs_valid = rs_valid_q;
  assign rs_code  = rs_code_q;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ck_fire |=> rs_valid); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_fire |=> !rs_valid); // R3
  AST_RELOAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_code == 2'd1) |-> ($past(ck_kind) == KIND_RELOAD)); // R3
  AST_RECOVER_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_code == 2'd2) |-> ($past(ck_kind) == KIND_BRANCH)); // R4
  AST_DEFER_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (al_fire && al_defer) |=>
      ($countones(valid_vec) <= $past($countones(valid_vec)))); // R6
endmodule

// File: tb/tb_spec_load_table.sv
`timescale 1ns/1ps
module tb_spec_load_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        al_valid = 1'b0, al_defer = 1'b0;
  logic [6:0]  al_reg = '0;
  logic [31:0] al_addr = '0;
  logic [1:0]  al_size = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic        ck_valid = 1'b0, ck_kind = 1'b0;
  logic [6:0]  ck_reg = '0;
  logic        al_ready, ck_ready, rs_valid;
  logic [1:0]  rs_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam int OK = 0, RELOAD = 1, RECOVER = 2;
  localparam bit RL = 1'b0, BR = 1'b1;

  always #2.5 clk = ~clk;

  spec_load_table dut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .al_valid(al_valid), .al_ready(al_ready), .al_reg(al_reg),
    .al_addr(al_addr), .al_size(al_size), .al_defer(al_defer),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .ck_valid(ck_valid), .ck_ready(ck_ready), .ck_reg(ck_reg),
    .ck_kind(ck_kind), .rs_valid(rs_valid), .rs_code(rs_code));

  task automatic expect_eq(input string req, input string what,
                           input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic alloc(input int r, input int a, input int sz, input bit dfr = 0);
    @(negedge clk);
    al_valid = 1; al_reg = 7'(r); al_addr = 32'(a); al_size = 2'(sz); al_defer = dfr;
    @(negedge clk);
    al_valid = 0; al_defer = 0;
  endtask

  task automatic store(input int a, input int sz);
    @(negedge clk);
    st_valid = 1; st_addr = 32'(a); st_size = 2'(sz);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic check(input string req, input int r, input bit kind, input int exp);
    @(negedge clk);
    ck_valid = 1; ck_reg = 7'(r); ck_kind = kind;
    @(negedge clk);
    ck_valid = 0;
    expect_eq(req, $sformatf("rs_valid reg%0d", r), int'(rs_valid), 1);
    expect_eq(req, $sformatf("rs_code reg%0d", r), int'(rs_code), exp);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1;
    #1;
    expect_eq("R10", "al_ready during flush", int'(al_ready), 0);
    expect_eq("R10", "ck_ready during flush", int'(ck_ready), 0);
    @(negedge clk);
    flush_all = 0;
  endtask

  task automatic t_reset();
    expect_eq("R1", "rs_valid after reset", int'(rs_valid), 0);
    expect_eq("R1", "al_ready after reset", int'(al_ready), 1);
    expect_eq("R1", "ck_ready after reset", int'(ck_ready), 1);
    check("R1", 3, BR, RECOVER);
    @(negedge clk);
    expect_eq("R3", "rs_valid idle", int'(rs_valid), 0);
  endtask

  task automatic t_hit_and_remove();
    alloc(5, 'h100, 3);
    check("R4", 5, BR, OK);
    check("R5", 5, BR, OK);
    check("R3", 5, RL, OK);
    check("R5", 5, RL, RELOAD);
    check("R4", 5, BR, RECOVER);
  endtask

  task automatic t_store_overlap();
    alloc(6, 'h200, 2);
    store('h203, 0);
    check("R7", 6, BR, RECOVER);
    alloc(7, 'h300, 2);
    store('h304, 2);
    store('h2FC, 2);
    check("R7", 7, BR, OK);
    store('h2FE, 2);
    check("R7", 7, RL, RELOAD);
  endtask

  task automatic t_defer();
    alloc(8, 'h700, 3);
    alloc(8, 'h700, 3, 1);
    check("R6", 8, BR, RECOVER);
    alloc(9, 'h780, 1, 1);
    check("R6", 9, RL, RELOAD);
  endtask

  task automatic t_replace();
    alloc(11, 'h400, 2);
    alloc(11, 'h500, 2);
    store('h400, 2);
    check("R2", 11, BR, OK);
    store('h502, 0);
    check("R2", 11, BR, RECOVER);
  endtask

  task automatic t_same_cycle();
    alloc(10, 'h600, 3);
    @(negedge clk);
    ck_valid = 1; ck_reg = 7'd10; ck_kind = BR;
    st_valid = 1; st_addr = 32'h604; st_size = 2'd0;
    @(negedge clk);
    ck_valid = 0; st_valid = 0;
    expect_eq("R8", "same-cycle code", int'(rs_code), RECOVER);
    check("R8", 10, BR, RECOVER);
  endtask

  task automatic t_full();
    do_flush();
    check("R10", 7, BR, RECOVER);
    for (int i = 0; i < 32; i++) alloc(20 + i, 'h1000 + i * 16, 3);
    check("R9", 20, BR, OK);
    alloc(60, 'h2000, 3);
    check("R9", 20, BR, RECOVER);
    check("R9", 21, BR, OK);
    check("R9", 60, BR, OK);
    alloc(61, 'h2100, 3);
    check("R9", 21, BR, RECOVER);
    check("R9", 22, BR, OK);
    check("R9", 51, BR, OK);
    do_flush();
    check("R10", 22, BR, RECOVER);
    check("R10", 60, RL, RELOAD);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hit_and_remove();
    t_store_overlap();
    t_defer();
    t_replace();
    t_same_cycle();
    t_full();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule